// File: doc/BRIEF.md
# Compare-Driven PWM Timer

This block is a free-standing 16-bit timer whose count is compared against one period register and against a set of channel compare registers. Each channel drives one waveform pin. A per-channel 3-bit output mode controls how the channel's own compare match and a shared "second action" event act on the pin. With these modes a channel can set, clear or toggle its pin on a single event, or run a two-event pattern such as a PWM. The counter advances only when a one-cycle `tick` strobe is high. It can hold, count up to the period value and wrap, run freely over the whole 16-bit range, or count up to the period value and back down to zero.

Software loads the counter, the period value, each channel's compare value, its output mode and its manual output bit through write strobes. Compare registers take a new value at once, with no staging copy. Two sticky flags report a period match and a counter overflow. Each flag has its own clear strobe. Compare events come only from counting. A software load or clear of the counter never fires one.

When the second action fires depends on the count mode. In up mode it fires on the tick that rolls the count from the period value back to zero. In free-running and up/down modes it fires on the tick where the count becomes equal to the period value. If a channel's own action and the second action fall on the same tick, the second action is applied first and the channel's own action last. This makes the outcome deterministic.

Top module: `pwm_timer_top`

## Requirements
- R1: After an active-low reset the count, every pin, both flags, the period value, every compare value, every output mode and every manual bit are zero.
- R2: Count mode 0 (stop) holds the count. A counter load (`cnt_we`) sets the count to `cnt_wdata` on the next edge, and a clear (`cnt_clr`, which wins over a load) sets it to zero. Neither raises a compare event, a second action or a flag.
- R3: Count mode 1 (up) steps the count by one per tick until it is at or above the period value. The next tick sets it to zero, so the period is period value + 1 ticks.
- R4: Count mode 2 (free-running) steps by one per tick and wraps from 0xFFFF to 0. The period value has no effect on the count.
- R5: Count mode 3 (up/down) counts up to the period value, then counts down one per tick to zero, then counts up again. The direction resets to up on a clear or in any other mode.
- R6: Output mode 0 copies the manual bit to the pin, two edges after the bit write. Single-action modes act only on the channel's own compare event, which is the tick where the count becomes equal to the channel's compare value: mode 1 sets the pin, mode 4 toggles it and mode 5 clears it.
- R7: In the double-action modes the own event acts first and the second action acts next. Mode 2 toggles then clears, mode 3 sets then clears, mode 6 toggles then sets and mode 7 clears then sets. The second action fires on the rollover tick in up mode and on the tick where the count reaches the period value in the other modes.
- R8: In up mode with output mode 7 and a compare value of period value + 1, the pin stays high once set.
- R9: When the own event and the second action land on the same tick, the own action is applied last. Mode 7 with compare value 0 in up mode keeps the pin low, and mode 2 with compare value 0 in up mode keeps it high.
- R10: The period flag is set on the tick where the count becomes equal to the period value and stays set until `per_flag_clr`. A set on the same edge wins over the clear.
- R11: The overflow flag is set when the count wraps to zero in up or free-running mode, or counts down onto zero in up/down mode. It clears on `ovf_flag_clr`, and a set wins.
- R12: With `tick` low the count, flags and pins in modes 1 to 7 do not change. Every result that a tick causes is visible right after the edge where that tick is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count enable |
| cnt_mode | input | 2 | Count mode: 0 stop, 1 up, 2 free-running, 3 up/down |
| cnt_we | input | 1 | Load the counter with `cnt_wdata` |
| cnt_wdata | input | 16 | Counter load value |
| cnt_clr | input | 1 | Clear counter and direction |
| per_we | input | 1 | Write the period value from `cmp_wdata` |
| cmp_wdata | input | 16 | Data for period and channel compare writes |
| chan_cmp_we | input | NCH | Per-channel compare value write |
| chan_mode_we | input | NCH | Per-channel output mode write |
| chan_mode_wdata | input | 3 | Output mode value |
| chan_bit_we | input | NCH | Per-channel manual bit write |
| chan_bit_wdata | input | 1 | Manual bit value |
| per_flag_clr | input | 1 | Clear the period flag |
| ovf_flag_clr | input | 1 | Clear the overflow flag |
| count_o | output | 16 | Current count |
| pwm_o | output | NCH | Channel pins |
| per_flag_o | output | 1 | Sticky period-match flag |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
The count, both flags and every pin in modes 1 to 7 react on the same edge that samples the tick that caused the event, so all of them are due one cycle after the stimulus. A manual-bit write reaches the pin in mode 0 two edges later. A compare, period or mode write takes part in events from the cycle after it. The bench drives every input on the falling edge, advances its own model by exactly one step per rising edge, and compares the outputs at the following falling edge. Every result is therefore checked in the cycle it becomes due, never earlier or later.

// File: rtl/pwm_timer_pkg.sv
// Shared encodings for the compare PWM timer.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        CM_STOP = 2'd0,
        CM_UP   = 2'd1,
        CM_FREE = 2'd2,
        CM_UPDN = 2'd3
    } cnt_mode_e;

    typedef enum logic [2:0] {
        OM_BIT     = 3'd0,
        OM_SET     = 3'd1,
        OM_TGL_CLR = 3'd2,
        OM_SET_CLR = 3'd3,
        OM_TGL     = 3'd4,
        OM_CLR     = 3'd5,
        OM_TGL_SET = 3'd6,
        OM_CLR_SET = 3'd7
    } out_mode_e;

endpackage

// File: rtl/pwm_tmr_counter.sv
// Counter core: holds the count, its direction and the period value.
// It works out the next count for the current mode and produces the
// per-tick events: the period match, the second action and the overflow.
// Assumes tick is a single-cycle strobe. Software loads and clears win
// over counting and never raise events.
module pwm_tmr_counter
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [1:0]    mode,
    input  logic          cnt_we,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          cnt_clr,
    input  logic          per_we,
    input  logic [CW-1:0] per_wdata,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] per_q,
    output logic          adv_o,
    output logic [CW-1:0] nxt_o,
    output logic          per_hit_o,
    output logic          second_o,
    output logic          ovf_evt_o
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};
    localparam logic [CW-1:0] ONE  = CW'(1);

    cnt_mode_e     mode_e;
    logic          dir_q;      // 1 = counting down
    logic [CW-1:0] nxt;
    logic          ndir;
    logic          wrap_up;
    logic          ovf;

    assign mode_e = cnt_mode_e'(mode);
    assign adv_o  = tick && (mode_e != CM_STOP) && !cnt_we && !cnt_clr;

    // Next count, next direction and raw events for the selected mode.
    always_comb begin
        nxt     = cnt_q;
        ndir    = dir_q;
        wrap_up = 1'b0;
        ovf     = 1'b0;
        unique case (mode_e)
            CM_UP: begin
                if (cnt_q >= per_q) begin
                    nxt     = '0;
                    wrap_up = 1'b1;
                    ovf     = 1'b1;
                end else begin
                    nxt = cnt_q + ONE;
                end
            end
            CM_FREE: begin
                nxt = cnt_q + ONE;
                ovf = (cnt_q == CMAX);
            end
            CM_UPDN: begin
                if (!dir_q) begin
                    if (cnt_q >= per_q) begin
                        if (cnt_q != '0) begin
                            nxt  = cnt_q - ONE;
                            ndir = 1'b1;
                            if (nxt == '0) begin
                                ndir = 1'b0;
                                ovf  = 1'b1;
                            end
                        end
                    end else begin
                        nxt = cnt_q + ONE;
                    end
                end else begin
                    if (cnt_q == '0) begin
                        nxt  = ONE;
                        ndir = 1'b0;
                    end else begin
                        nxt = cnt_q - ONE;
                        if (nxt == '0) begin
                            ndir = 1'b0;
                            ovf  = 1'b1;
                        end
                    end
                end
            end
            default: ;
        endcase
    end

    assign nxt_o     = nxt;
    assign per_hit_o = adv_o && (nxt == per_q);
    assign second_o  = (mode_e == CM_UP) ? (adv_o && wrap_up) : per_hit_o;
    assign ovf_evt_o = adv_o && ovf;

    // Count register: clear, then load, then counting.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_clr) cnt_q <= '0;
        else if (cnt_we)  cnt_q <= cnt_wdata;
        else if (adv_o)   cnt_q <= nxt;
    end

    // Direction register, only meaningful in up/down mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                            dir_q <= 1'b0;
        else if (cnt_clr || mode_e != CM_UPDN) dir_q <= 1'b0;
        else if (adv_o)                        dir_q <= ndir;
    end

    // Period register, written directly with no staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n)      per_q <= '0;
        else if (per_we) per_q <= per_wdata;
    end

endmodule

// File: rtl/pwm_tmr_channel.sv
// One output channel: compare value, output mode, manual bit and the
// registered pin. On a tick it applies the second action first and its
// own compare action last, so two opposing actions on one tick resolve
// deterministically. Assumes the events come from pwm_tmr_counter.
module pwm_tmr_channel
    import pwm_timer_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] nxt,
    input  logic          second,
    input  logic          cmp_we,
    input  logic [CW-1:0] cmp_wdata,
    input  logic          mode_we,
    input  logic [2:0]    mode_wdata,
    input  logic          bit_we,
    input  logic          bit_wdata,
    output logic          pin_o
);
    logic [CW-1:0] cmp_q;
    out_mode_e     mode_q;
    logic          bit_q;
    logic          own_evt;
    logic          after_sec;
    logic          pin_d;

    assign own_evt = adv && (nxt == cmp_q);

    // Pin update: second action first, then the channel's own action.
    always_comb begin
        after_sec = pin_o;
        if (second) begin
            unique case (mode_q)
                OM_TGL_CLR, OM_SET_CLR: after_sec = 1'b0;
                OM_TGL_SET, OM_CLR_SET: after_sec = 1'b1;
                default: ;
            endcase
        end
        pin_d = after_sec;
        if (own_evt) begin
            unique case (mode_q)
                OM_SET, OM_SET_CLR:             pin_d = 1'b1;
                OM_TGL, OM_TGL_CLR, OM_TGL_SET: pin_d = ~after_sec;
                OM_CLR, OM_CLR_SET:             pin_d = 1'b0;
                default: ;
            endcase
        end
        if (mode_q == OM_BIT) pin_d = bit_q;
    end

    // Channel configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mode_q <= OM_BIT;
            bit_q  <= 1'b0;
        end else begin
            if (cmp_we)  cmp_q  <= cmp_wdata;
            if (mode_we) mode_q <= out_mode_e'(mode_wdata);
            if (bit_we)  bit_q  <= bit_wdata;
        end
    end

    // Registered pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_o <= 1'b0;
        else        pin_o <= pin_d;
    end

endmodule

// File: rtl/pwm_tmr_flags.sv
// Sticky period-match and overflow flags. A set on the same edge wins
// over the clear strobe. Assumes one-cycle event strobes.
module pwm_tmr_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic per_hit,
    input  logic ovf_evt,
    input  logic per_clr,
    input  logic ovf_clr,
    output logic per_flag_o,
    output logic ovf_flag_o
);
    // Period-match flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       per_flag_o <= 1'b0;
        else if (per_hit) per_flag_o <= 1'b1;
        else if (per_clr) per_flag_o <= 1'b0;
    end

    // Overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovf_flag_o <= 1'b0;
        else if (ovf_evt) ovf_flag_o <= 1'b1;
        else if (ovf_clr) ovf_flag_o <= 1'b0;
    end

endmodule

// File: rtl/pwm_timer_top.sv
// Top of the compare PWM timer: one counter core, NCH output channels
// built by generate, and the two sticky flags. Assumes all write
// strobes are synchronous single-cycle pulses.
module pwm_timer_top #(
    parameter int CW  = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [1:0]     cnt_mode,
    input  logic           cnt_we,
    input  logic [CW-1:0]  cnt_wdata,
    input  logic           cnt_clr,
    input  logic           per_we,
    input  logic [CW-1:0]  cmp_wdata,
    input  logic [NCH-1:0] chan_cmp_we,
    input  logic [NCH-1:0] chan_mode_we,
    input  logic [2:0]     chan_mode_wdata,
    input  logic [NCH-1:0] chan_bit_we,
    input  logic           chan_bit_wdata,
    input  logic           per_flag_clr,
    input  logic           ovf_flag_clr,
    output logic [CW-1:0]  count_o,
    output logic [NCH-1:0] pwm_o,
    output logic           per_flag_o,
    output logic           ovf_flag_o
);
    logic [CW-1:0] per_q;
    logic          adv;
    logic [CW-1:0] nxt;
    logic          per_hit;
    logic          second;
    logic          ovf_evt;

    pwm_tmr_counter #(.CW(CW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (cnt_mode),
        .cnt_we    (cnt_we),
        .cnt_wdata (cnt_wdata),
        .cnt_clr   (cnt_clr),
        .per_we    (per_we),
        .per_wdata (cmp_wdata),
        .cnt_q     (count_o),
        .per_q     (per_q),
        .adv_o     (adv),
        .nxt_o     (nxt),
        .per_hit_o (per_hit),
        .second_o  (second),
        .ovf_evt_o (ovf_evt)
    );

    for (genvar gi = 0; gi < NCH; gi++) begin : g_chan
        pwm_tmr_channel #(.CW(CW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .adv        (adv),
            .nxt        (nxt),
            .second     (second),
            .cmp_we     (chan_cmp_we[gi]),
            .cmp_wdata  (cmp_wdata),
            .mode_we    (chan_mode_we[gi]),
            .mode_wdata (chan_mode_wdata),
            .bit_we     (chan_bit_we[gi]),
            .bit_wdata  (chan_bit_wdata),
            .pin_o      (pwm_o[gi])
        );
    end

    pwm_tmr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .per_hit    (per_hit),
        .ovf_evt    (ovf_evt),
        .per_clr    (per_flag_clr),
        .ovf_clr    (ovf_flag_clr),
        .per_flag_o (per_flag_o),
        .ovf_flag_o (ovf_flag_o)
    );

endmodule

// File: rtl/pwm_timer_chk.sv
// Property checker for pwm_timer_top, attached with bind. It watches
// the top-level ports and the period register.
module pwm_timer_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic [1:0]    cnt_mode,
    input logic          cnt_we,
    input logic [CW-1:0] cnt_wdata,
    input logic          cnt_clr,
    input logic          per_we,
    input logic [CW-1:0] count_o,
    input logic [CW-1:0] per_q,
    input logic          per_flag_o,
    input logic          ovf_flag_o
);
    // R2
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_mode == 2'd0 && !cnt_we && !cnt_clr) |=> $stable(count_o));

    // R2
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_we && !cnt_clr) |=> (count_o == $past(cnt_wdata)));

    // R2
    write_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_we || cnt_clr) && !per_flag_o && !ovf_flag_o) |=> (!per_flag_o && !ovf_flag_o));

    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_mode == 2'd1 && !cnt_we && !cnt_clr && count_o >= per_q) |=> (count_o == '0));

    // R4
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_mode == 2'd2 && !cnt_we && !cnt_clr) |=> (count_o == $past(count_o) + CW'(1)));

    // R10
    per_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(per_flag_o) && !$past(per_we)) |-> (count_o == per_q));

    // R11
    ovf_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag_o) |-> (count_o == '0));

endmodule

bind pwm_timer_top pwm_timer_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cnt_mode   (cnt_mode),
    .cnt_we     (cnt_we),
    .cnt_wdata  (cnt_wdata),
    .cnt_clr    (cnt_clr),
    .per_we     (per_we),
    .count_o    (count_o),
    .per_q      (per_q),
    .per_flag_o (per_flag_o),
    .ovf_flag_o (ovf_flag_o)
);

// File: tb/pwm_timer_top_test.sv
`timescale 1ns/1ps
module pwm_timer_top_test;
    localparam int CW  = 16;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           tick;
    logic [1:0]     cnt_mode;
    logic           cnt_we;
    logic [CW-1:0]  cnt_wdata;
    logic           cnt_clr;
    logic           per_we;
    logic [CW-1:0]  cmp_wdata;
    logic [NCH-1:0] chan_cmp_we;
    logic [NCH-1:0] chan_mode_we;
    logic [2:0]     chan_mode_wdata;
    logic [NCH-1:0] chan_bit_we;
    logic           chan_bit_wdata;
    logic           per_flag_clr;
    logic           ovf_flag_clr;
    logic [CW-1:0]  count_o;
    logic [NCH-1:0] pwm_o;
    logic           per_flag_o;
    logic           ovf_flag_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // Bench model state
    logic [CW-1:0] m_cnt, m_per;
    logic          m_dir;
    logic [CW-1:0] m_cmp [NCH];
    logic [2:0]    m_om  [NCH];
    logic          m_bit [NCH];
    logic          m_out [NCH];
    logic          m_pf, m_of;

    always #2.5 clk = ~clk;

    pwm_timer_top #(.CW(CW), .NCH(NCH)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_per = '0; m_dir = 1'b0; m_pf = 1'b0; m_of = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            m_cmp[i] = '0; m_om[i] = 3'd0; m_bit[i] = 1'b0; m_out[i] = 1'b0;
        end
    endtask

    // One model step from the current inputs, built from R2..R12.
    task automatic model_step();
        logic [CW-1:0] nx;
        logic nd, adv, wrap, ovf, hit, sec, eqx, o;
        adv = tick && cnt_mode != 2'd0 && !cnt_we && !cnt_clr;
        nx = m_cnt; nd = m_dir; wrap = 1'b0; ovf = 1'b0;
        case (cnt_mode)
            2'd1: if (m_cnt >= m_per) begin nx = '0; wrap = 1'b1; ovf = 1'b1; end
                  else nx = m_cnt + 1'b1;
            2'd2: begin nx = m_cnt + 1'b1; ovf = (m_cnt == '1); end
            2'd3: begin
                if (!m_dir) begin
                    if (m_cnt < m_per) nx = m_cnt + 1'b1;
                    else if (m_cnt != '0) begin
                        nx = m_cnt - 1'b1; nd = 1'b1;
                        if (nx == '0) begin nd = 1'b0; ovf = 1'b1; end
                    end
                end else if (m_cnt == '0) begin
                    nx = 16'd1; nd = 1'b0;
                end else begin
                    nx = m_cnt - 1'b1;
                    if (nx == '0) begin nd = 1'b0; ovf = 1'b1; end
                end
            end
            default: ;
        endcase
        hit = adv && (nx == m_per);
        sec = (cnt_mode == 2'd1) ? (adv && wrap) : hit;
        ovf = adv && ovf;
        for (int i = 0; i < NCH; i++) begin
            eqx = adv && (nx == m_cmp[i]);
            o = m_out[i];
            if (m_om[i] == 3'd0) o = m_bit[i];
            else begin
                if (sec) begin
                    if (m_om[i] == 3'd2 || m_om[i] == 3'd3) o = 1'b0;
                    if (m_om[i] == 3'd6 || m_om[i] == 3'd7) o = 1'b1;
                end
                if (eqx) begin
                    if (m_om[i] == 3'd1 || m_om[i] == 3'd3) o = 1'b1;
                    else if (m_om[i] == 3'd5 || m_om[i] == 3'd7) o = 1'b0;
                    else o = ~o;
                end
            end
            m_out[i] = o;
            if (chan_cmp_we[i])  m_cmp[i] = cmp_wdata;
            if (chan_mode_we[i]) m_om[i]  = chan_mode_wdata;
            if (chan_bit_we[i])  m_bit[i] = chan_bit_wdata;
        end
        if (hit) m_pf = 1'b1; else if (per_flag_clr) m_pf = 1'b0;
        if (ovf) m_of = 1'b1; else if (ovf_flag_clr) m_of = 1'b0;
        if (cnt_clr) m_cnt = '0;
        else if (cnt_we) m_cnt = cnt_wdata;
        else if (adv) m_cnt = nx;
        if (cnt_clr || cnt_mode != 2'd3) m_dir = 1'b0;
        else if (adv) m_dir = nd;
        if (per_we) m_per = cmp_wdata;
    endtask

    task automatic clear_strobes();
        cnt_we = 1'b0; cnt_clr = 1'b0; per_we = 1'b0;
        chan_cmp_we = '0; chan_mode_we = '0; chan_bit_we = '0;
        per_flag_clr = 1'b0; ovf_flag_clr = 1'b0;
    endtask

    // Advance one clock, then compare every output with the model.
    task automatic step();
        string cr;
        model_step();
        @(posedge clk);
        @(negedge clk);
        case (cnt_mode)
            2'd0: cr = "R2"; 2'd1: cr = "R3"; 2'd2: cr = "R4"; default: cr = "R5";
        endcase
        chk(count_o == m_cnt, cr, "count", count_o, m_cnt);
        for (int i = 0; i < NCH; i++)
            chk(pwm_o[i] == m_out[i],
                (m_om[i] inside {3'd2, 3'd3, 3'd6, 3'd7}) ? "R7" : "R6",
                $sformatf("pin%0d", i), pwm_o[i], m_out[i]);
        chk(per_flag_o == m_pf, "R10", "period flag", per_flag_o, m_pf);
        chk(ovf_flag_o == m_of, "R11", "overflow flag", ovf_flag_o, m_of);
        clear_strobes();
    endtask

    task automatic wr_per(input int v);
        per_we = 1'b1; cmp_wdata = CW'(v); step();
    endtask

    task automatic wr_chan(input int ch, input int om, input int cv);
        chan_mode_we[ch] = 1'b1; chan_mode_wdata = 3'(om);
        chan_cmp_we[ch] = 1'b1; cmp_wdata = CW'(cv); step();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL R12 watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lows, highs;
        logic [CW-1:0] hold;
        void'($urandom(32'd20240611));
        tick = 1'b0; cnt_mode = 2'd0; cnt_wdata = '0; cmp_wdata = '0;
        chan_mode_wdata = '0; chan_bit_wdata = 1'b0; clear_strobes();
        rst_n = 1'b0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(count_o == '0, "R1", "count", count_o, 0);
        chk(pwm_o == '0, "R1", "pins", pwm_o, 0);
        chk(!per_flag_o && !ovf_flag_o, "R1", "flags", {per_flag_o, ovf_flag_o}, 0);

        // R6: manual bit drives pin in mode 0
        chan_bit_we[0] = 1'b1; chan_bit_wdata = 1'b1; step(); step();
        chk(pwm_o[0] == 1'b1, "R6", "manual bit", pwm_o[0], 1);

        // R8 on ch0 (mode 7, compare = period+1), R9 on ch1 (mode 7, compare 0)
        wr_per(5);
        wr_chan(0, 7, 6);
        wr_chan(1, 7, 0);
        cnt_mode = 2'd1; tick = 1'b1;
        repeat (10) step();
        lows = 0; highs = 0;
        for (int k = 0; k < 36; k++) begin
            step();
            if (!pwm_o[0]) lows++;
            if (pwm_o[1]) highs++;
        end
        chk(lows == 0, "R8", "full duty lows", lows, 0);
        chk(highs == 0, "R9", "zero duty highs", highs, 0);

        // R9: toggle/clear with compare 0 stays high after rollovers
        wr_chan(1, 2, 0);
        repeat (8) step();
        highs = 0;
        for (int k = 0; k < 24; k++) begin step(); if (pwm_o[1]) highs++; end
        chk(highs == 24, "R9", "toggle/clear highs", highs, 24);

        // R12: tick low holds count and pins
        tick = 1'b0; hold = count_o;
        repeat (5) step();
        chk(count_o == hold, "R12", "count without tick", count_o, hold);

        // R2: loading the period value by software raises no flag
        per_flag_clr = 1'b1; ovf_flag_clr = 1'b1; step();
        cnt_we = 1'b1; cnt_wdata = 16'd5; step();
        cnt_clr = 1'b1; step();
        chk(!per_flag_o && !ovf_flag_o, "R2", "flags after write", {per_flag_o, ovf_flag_o}, 0);

        // R4 and R11: free-running wrap past 0xFFFF
        cnt_mode = 2'd2; cnt_we = 1'b1; cnt_wdata = 16'hFFFD; step();
        tick = 1'b1;
        repeat (4) step();
        chk(count_o == 16'd1, "R4", "count after wrap", count_o, 1);
        chk(ovf_flag_o, "R11", "overflow after wrap", ovf_flag_o, 1);

        // R5: up/down turns at the period value
        cnt_clr = 1'b1; step();
        cnt_mode = 2'd3;
        repeat (7) step();
        chk(count_o == 16'd3, "R5", "count on way down", count_o, 3);

        // Random segments checked cycle by cycle against the model
        for (int seg = 0; seg < 40; seg++) begin
            tick = 1'b0;
            wr_per($urandom_range(12));
            for (int i = 0; i < NCH; i++)
                wr_chan(i, $urandom_range(7), $urandom_range(14));
            cnt_mode = 2'($urandom_range(3));
            for (int k = 0; k < 120; k++) begin
                tick = ($urandom_range(3) != 0);
                if ($urandom_range(99) < 2) begin
                    cnt_we = 1'b1;
                    cnt_wdata = ($urandom_range(1) != 0) ? CW'($urandom_range(14))
                                                         : CW'(16'hFFF0 + $urandom_range(15));
                end
                if ($urandom_range(99) < 1) cnt_clr = 1'b1;
                if ($urandom_range(99) < 8) per_flag_clr = 1'b1;
                if ($urandom_range(99) < 8) ovf_flag_clr = 1'b1;
                if ($urandom_range(99) < 3) begin
                    chan_bit_we[$urandom_range(NCH-1)] = 1'b1;
                    chan_bit_wdata = 1'($urandom_range(1));
                end
                step();
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule